// File: doc/BRIEF.md
# Instruction-Framed SPI Register Port

This block is the host-facing serial port of an encoder counter core. An external SPI master (clock idle low, data captured on the rising clock edge) selects the port and sends an instruction byte. Depending on the instruction, the port either fires a single clear or load strobe, returns the contents of a core register, or collects data bytes and hands them to the core as a write.

All three serial inputs are asynchronous to the system clock. They pass through a synchronizer chain and are edge-detected there, so the host clock has to be several times slower than the system clock.

The number of data bytes moved for the preset, count and snapshot registers follows a width setting of 1 to 4 bytes supplied by the core. The two mode registers and the status register always move one byte. Once the byte count of a command is used up, the rest of the frame is ignored.

Top module: `spi_regif`

## Requirements
- R1: A frame opens when the select line goes low, and its first 8 bits form an instruction. Bits [7:6] give the action: 00 clear, 01 read, 10 write, 11 load. Bits [5:3] give the target: 001 mode A, 010 mode B, 011 preset, 100 count, 101 snapshot, 110 status. The target code appears on `reg_sel` with every strobe.
- R2: MOSI is taken on the rising SCK edge, most significant bit first, for both the instruction and the data bytes.
- R3: In a read frame, `rd_stb` pulses once after the instruction. MISO then presents the requested bytes most significant bit first, updating after falling SCK edges. Those bytes are the low bytes of `rd_data`.
- R4: Preset, count and snapshot transfer `cfg_width`+1 bytes (00 gives 1 byte, 11 gives 4 bytes). Mode A, mode B and status transfer exactly one byte at any width.
- R5: A write strobe is issued only after the select line returns high, and only if the full byte count was received. `wr_data` holds the received bytes right-aligned, with the upper bits zero.
- R6: Bits sent after the byte count is complete are ignored. Write data keeps the first bytes, and MISO returns zero for the excess bits.
- R7: A read frame never produces a write, because MOSI is not used during its data phase. A write frame returns zero on MISO. At most one strobe is active in any cycle.
- R8: Clear and load instructions issue one `clr_stb` or `ld_stb` pulse after the instruction byte and take no data.
- R9: Each frame executes at most one command. A frame dropped before its instruction byte completes produces no strobe. Only a new high-then-low select starts a new command.
- R10: While the select line is high, `spi_miso` is low and `spi_miso_oe` is low. While it is low, `spi_miso_oe` is high.
- R11: Target codes 000 and 111 produce no strobe for any action.
- R12: After reset all strobes are low and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for MISO |
| cfg_width | input | 2 | Wide-register byte count minus one |
| reg_sel | output | 3 | Target register code of the current command |
| rd_stb | output | 1 | One-cycle read request to the core |
| rd_data | input | 8*MAX_BYTES | Register value returned by the core, sampled the cycle after `rd_stb` |
| wr_stb | output | 1 | One-cycle write commit |
| wr_data | output | 8*MAX_BYTES | Write value, right-aligned |
| clr_stb | output | 1 | One-cycle clear request |
| ld_stb | output | 1 | One-cycle load request |

## Verification
Writes are sent at every width to the wide registers and at full width to the single-byte registers. Matching data values show that the byte count tracks both the target and `cfg_width`, rather than either one alone. Reads are sent while MOSI carries all ones or a well-formed write instruction, which separates a port that ignores MOSI during readout from one that keeps decoding it. Frames with extra trailing bytes, frames that are one byte short, frames dropped in mid-instruction and frames with reserved target codes are all sent. Each one must produce either exactly one strobe or none, so the byte-count boundaries are probed from both sides.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

   typedef enum logic [1:0] {
      OP_CLR = 2'b00,
      OP_RD  = 2'b01,
      OP_WR  = 2'b10,
      OP_LD  = 2'b11
   } op_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_INSTR,
      PH_DATA,
      PH_DONE
   } phase_e;

   localparam logic [2:0] TGT_MODE_A = 3'b001;
   localparam logic [2:0] TGT_MODE_B = 3'b010;
   localparam logic [2:0] TGT_PRESET = 3'b011;
   localparam logic [2:0] TGT_COUNT  = 3'b100;
   localparam logic [2:0] TGT_SNAP   = 3'b101;
   localparam logic [2:0] TGT_STATUS = 3'b110;

   function automatic logic tgt_valid(input logic [2:0] t);
      return (t != 3'b000) && (t != 3'b111);
   endfunction

   function automatic logic tgt_wide(input logic [2:0] t);
      return (t == TGT_PRESET) || (t == TGT_COUNT) || (t == TGT_SNAP);
   endfunction

endpackage

// File: rtl/spi_regif_sync.sv
module spi_regif_sync #(
   parameter int           STAGES  = 2,
   parameter int           NSIG    = 3,
   parameter logic [NSIG-1:0] RST_VAL = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSIG-1:0] din,
   output logic [NSIG-1:0] dout
);

   initial begin
      AST_CFG_STAGES: assert (STAGES >= 2) else $error("sync needs two or more stages");
   end

   for (genvar g = 0; g < NSIG; g++) begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= {STAGES{RST_VAL[g]}};
         else        sh <= {sh[STAGES-2:0], din[g]};
      end
      assign dout[g] = sh[STAGES-1];
   end

endmodule

// File: rtl/spi_regif_frame.sv
module spi_regif_frame
   import spi_regif_pkg::*;
#(
   parameter int MAX_BYTES = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         sck_lvl,
   input  logic                         cs_lvl,
   input  logic                         mosi_lvl,
   input  logic [1:0]                   cfg_width,
   output logic                         sck_fall,
   output logic                         cs_fall,
   output logic                         tx_en,
   output logic [$clog2(8*MAX_BYTES+1)-1:0] nbits,
   output logic [2:0]                   reg_sel,
   output logic                         rd_stb,
   output logic                         wr_stb,
   output logic                         clr_stb,
   output logic                         ld_stb,
   output logic [8*MAX_BYTES-1:0]       wr_data
);

   localparam int DW = 8 * MAX_BYTES;
   localparam int CW = $clog2(DW + 1);

   logic          sck_q, cs_q;
   logic          sck_rise, cs_rise;
   phase_e        phase_q;
   op_e           op_q;
   logic [6:0]    instr_sh;
   logic [7:0]    nxt_instr;
   logic [CW-1:0] bitcnt_q;
   logic [CW-1:0] nbits_q;
   logic [CW-1:0] nbits_dec;
   logic [DW-1:0] dshift_q;
   logic          wr_full_q;
   logic          cmd_seen_q;

   // edge detection on the synchronized levels
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b1;
      end else begin
         sck_q <= sck_lvl;
         cs_q  <= cs_lvl;
      end
   end

   assign sck_rise = sck_lvl & ~sck_q;
   assign sck_fall = ~sck_lvl & sck_q;
   assign cs_rise  = cs_lvl & ~cs_q;
   assign cs_fall  = ~cs_lvl & cs_q;

   assign nxt_instr = {instr_sh, mosi_lvl};

   // byte count of the command being decoded
   if (MAX_BYTES == 1) begin : g_fixed_count
      assign nbits_dec = CW'(8);
   end else begin : g_sized_count
      always_comb begin
         int b;
         b = tgt_wide(nxt_instr[5:3]) ? int'(cfg_width) + 1 : 1;
         if (b > MAX_BYTES) b = MAX_BYTES;
         nbits_dec = CW'(b * 8);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         op_q       <= OP_CLR;
         instr_sh   <= '0;
         bitcnt_q   <= '0;
         nbits_q    <= CW'(8);
         dshift_q   <= '0;
         wr_full_q  <= 1'b0;
         reg_sel    <= '0;
         rd_stb     <= 1'b0;
         wr_stb     <= 1'b0;
         clr_stb    <= 1'b0;
         ld_stb     <= 1'b0;
      end else begin
         rd_stb  <= 1'b0;
         wr_stb  <= 1'b0;
         clr_stb <= 1'b0;
         ld_stb  <= 1'b0;
         if (cs_fall) begin
            phase_q   <= PH_INSTR;
            bitcnt_q  <= '0;
            wr_full_q <= 1'b0;
         end else if (cs_rise) begin
            if (phase_q == PH_DONE && op_q == OP_WR && wr_full_q) wr_stb <= 1'b1;
            phase_q <= PH_IDLE;
         end else if (sck_rise) begin
            case (phase_q)
               PH_INSTR: begin
                  instr_sh <= nxt_instr[6:0];
                  bitcnt_q <= bitcnt_q + CW'(1);
                  if (bitcnt_q == CW'(7)) begin
                     op_q     <= op_e'(nxt_instr[7:6]);
                     reg_sel  <= nxt_instr[5:3];
                     nbits_q  <= nbits_dec;
                     bitcnt_q <= '0;
                     dshift_q <= '0;
                     if (!tgt_valid(nxt_instr[5:3])) begin
                        phase_q <= PH_DONE;
                     end else begin
                        case (op_e'(nxt_instr[7:6]))
                           OP_CLR: begin clr_stb <= 1'b1; phase_q <= PH_DONE; end
                           OP_LD:  begin ld_stb  <= 1'b1; phase_q <= PH_DONE; end
                           OP_RD:  begin rd_stb  <= 1'b1; phase_q <= PH_DATA; end
                           default: phase_q <= PH_DATA;
                        endcase
                     end
                  end
               end
               PH_DATA: begin
                  bitcnt_q <= bitcnt_q + CW'(1);
                  if (op_q == OP_WR) dshift_q <= {dshift_q[DW-2:0], mosi_lvl};
                  if (bitcnt_q == nbits_q - CW'(1)) begin
                     phase_q <= PH_DONE;
                     if (op_q == OP_WR) wr_full_q <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign tx_en   = (op_q == OP_RD) && (phase_q == PH_DATA || phase_q == PH_DONE);
   assign nbits   = nbits_q;
   assign wr_data = dshift_q;

   // checker bookkeeping: one command per frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cmd_seen_q <= 1'b0;
      else if (cs_fall)                    cmd_seen_q <= 1'b0;
      else if (rd_stb || clr_stb || ld_stb) cmd_seen_q <= 1'b1;
   end

   AST_DATA_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DATA) |-> (bitcnt_q < nbits_q)); // R4
   AST_WR_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (cs_lvl && $past(cs_lvl))); // R5
   AST_RD_IGNORES_MOSI: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DATA && op_q == OP_RD) |-> (dshift_q == '0)); // R7
   AST_ONE_CMD_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb || clr_stb || ld_stb) |-> !cmd_seen_q); // R9

endmodule

// File: rtl/spi_regif_txshift.sv
module spi_regif_txshift #(
   parameter int MAX_BYTES = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cs_fall,
   input  logic                             sck_fall,
   input  logic                             tx_en,
   input  logic                             rd_stb,
   input  logic [$clog2(8*MAX_BYTES+1)-1:0] nbits,
   input  logic [8*MAX_BYTES-1:0]           rd_data,
   output logic                             miso_q
);

   localparam int DW = 8 * MAX_BYTES;
   localparam int CW = $clog2(DW + 1);

   logic [DW-1:0] oshift_q;
   logic          load_q;
   logic [CW-1:0] shamt;

   // left-align the requested low bytes so the shift-out starts at their MSB
   assign shamt = CW'(DW) - nbits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oshift_q <= '0;
         load_q   <= 1'b0;
         miso_q   <= 1'b0;
      end else begin
         load_q <= rd_stb;
         if (cs_fall) begin
            oshift_q <= '0;
            miso_q   <= 1'b0;
         end else if (load_q) begin
            oshift_q <= rd_data << shamt;
         end else if (sck_fall && tx_en) begin
            miso_q   <= oshift_q[DW-1];
            oshift_q <= {oshift_q[DW-2:0], 1'b0};
         end
      end
   end

   AST_MISO_ON_SCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(miso_q) |-> ($past(sck_fall) || $past(cs_fall))); // R3

endmodule

// File: rtl/spi_regif.sv
module spi_regif #(
   parameter int MAX_BYTES   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   spi_sck,
   input  logic                   spi_cs_n,
   input  logic                   spi_mosi,
   output logic                   spi_miso,
   output logic                   spi_miso_oe,
   input  logic [1:0]             cfg_width,
   output logic [2:0]             reg_sel,
   output logic                   rd_stb,
   input  logic [8*MAX_BYTES-1:0] rd_data,
   output logic                   wr_stb,
   output logic [8*MAX_BYTES-1:0] wr_data,
   output logic                   clr_stb,
   output logic                   ld_stb
);

   localparam int CW = $clog2(8 * MAX_BYTES + 1);

   initial begin
      AST_CFG_BYTES: assert (MAX_BYTES >= 1 && MAX_BYTES <= 4) else $error("MAX_BYTES out of range");
   end

   logic [2:0]    lvl;
   logic          sck_fall, cs_fall, tx_en, miso_q;
   logic [CW-1:0] nbits;

   spi_regif_sync #(
      .STAGES (SYNC_STAGES),
      .NSIG   (3),
      .RST_VAL(3'b100)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({spi_cs_n, spi_sck, spi_mosi}),
      .dout (lvl)
   );

   spi_regif_frame #(.MAX_BYTES(MAX_BYTES)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_lvl  (lvl[1]),
      .cs_lvl   (lvl[2]),
      .mosi_lvl (lvl[0]),
      .cfg_width(cfg_width),
      .sck_fall (sck_fall),
      .cs_fall  (cs_fall),
      .tx_en    (tx_en),
      .nbits    (nbits),
      .reg_sel  (reg_sel),
      .rd_stb   (rd_stb),
      .wr_stb   (wr_stb),
      .clr_stb  (clr_stb),
      .ld_stb   (ld_stb),
      .wr_data  (wr_data)
   );

   spi_regif_txshift #(.MAX_BYTES(MAX_BYTES)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_fall (cs_fall),
      .sck_fall(sck_fall),
      .tx_en   (tx_en),
      .rd_stb  (rd_stb),
      .nbits   (nbits),
      .rd_data (rd_data),
      .miso_q  (miso_q)
   );

   assign spi_miso    = miso_q & ~spi_cs_n;
   assign spi_miso_oe = ~spi_cs_n;

   AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_stb, wr_stb, clr_stb, ld_stb})); // R7

endmodule

// File: tb/spi_regif_bench.sv
`timescale 1ns/1ps
module spi_regif_bench;

   localparam logic [2:0] K_NONE = 3'd0, K_RD = 3'd1, K_WR = 3'd2, K_CLR = 3'd3, K_LD = 3'd4;
   localparam int NV = 16;
   // fields: cfg[90:89] instr[88:81] nsent[80:78] txdata[77:38] kind[37:35] wdata[34:3] rbytes[2:0]
   localparam logic [90:0] VEC [0:NV-1] = '{
      {2'd0, 8'h98, 3'd1, 40'h5A,         K_WR,   32'h5A,       3'd0},
      {2'd1, 8'h98, 3'd2, 40'hBEEF,       K_WR,   32'hBEEF,     3'd0},
      {2'd3, 8'h98, 3'd4, 40'h12345678,   K_WR,   32'h12345678, 3'd0},
      {2'd2, 8'hA0, 3'd3, 40'hC0FFEE,     K_WR,   32'hC0FFEE,   3'd0},
      {2'd3, 8'h88, 3'd1, 40'h3C,         K_WR,   32'h3C,       3'd0},
      {2'd3, 8'h90, 3'd2, 40'h7E81,       K_WR,   32'h7E,       3'd0},
      {2'd1, 8'h60, 3'd2, 40'hFFFF,       K_RD,   32'h0,        3'd2},
      {2'd3, 8'h68, 3'd4, 40'hA5A5A5A5,   K_RD,   32'h0,        3'd4},
      {2'd3, 8'h70, 3'd2, 40'hFFFF,       K_RD,   32'h0,        3'd1},
      {2'd0, 8'h20, 3'd0, 40'h0,          K_CLR,  32'h0,        3'd0},
      {2'd0, 8'hE8, 3'd0, 40'h0,          K_LD,   32'h0,        3'd0},
      {2'd1, 8'hB8, 3'd2, 40'h1234,       K_NONE, 32'h0,        3'd0},
      {2'd1, 8'h98, 3'd1, 40'h77,         K_NONE, 32'h0,        3'd0},
      {2'd0, 8'h20, 3'd2, 40'h2020,       K_CLR,  32'h0,        3'd0},
      {2'd2, 8'h60, 3'd4, 40'h98AABBCC,   K_RD,   32'h0,        3'd3},
      {2'd0, 8'h00, 3'd1, 40'h55,         K_NONE, 32'h0,        3'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sck = 1'b0;
   logic        spi_cs_n = 1'b1;
   logic        spi_mosi = 1'b0;
   logic        spi_miso, spi_miso_oe;
   logic [1:0]  cfg_width = 2'd0;
   logic [2:0]  reg_sel;
   logic        rd_stb, wr_stb, clr_stb, ld_stb;
   logic [31:0] rd_data, wr_data;

   int n_checks = 0;
   int n_err    = 0;
   int n_rd = 0, n_wr = 0, n_clr = 0, n_ld = 0;
   logic [31:0] last_wdata = '0;
   logic [2:0]  last_sel = '0;

   always #2 clk = ~clk;

   function automatic logic [31:0] rd_model(input logic [2:0] s);
      return 32'h9E3CA751 ^ {8{1'b0, s}};
   endfunction

   assign rd_data = rd_model(reg_sel);

   spi_regif u_spi_regif (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
      .cfg_width(cfg_width), .reg_sel(reg_sel), .rd_stb(rd_stb), .rd_data(rd_data),
      .wr_stb(wr_stb), .wr_data(wr_data), .clr_stb(clr_stb), .ld_stb(ld_stb)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_stb)  begin n_rd++;  last_sel = reg_sel; end
         if (clr_stb) begin n_clr++; last_sel = reg_sel; end
         if (ld_stb)  begin n_ld++;  last_sel = reg_sel; end
         if (wr_stb)  begin n_wr++;  last_sel = reg_sel; last_wdata = wr_data; end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic xfer(input int nb, input logic [47:0] tx, output logic [47:0] rx);
      rx = '0;
      @(negedge clk);
      spi_cs_n = 1'b0;
      repeat (8) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         spi_mosi = tx[47-i];
         repeat (8) @(negedge clk);
         rx[47-i] = spi_miso;
         spi_sck = 1'b1;
         repeat (8) @(negedge clk);
         spi_sck = 1'b0;
      end
      repeat (8) @(negedge clk);
      spi_cs_n = 1'b1;
      spi_mosi = 1'b0;
      repeat (16) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end

   initial begin
      logic [47:0] rx48, tx48, exp48;
      logic [63:0] mval;
      repeat (5) @(negedge clk);
      // R12: reset state
      check(!rd_stb && !wr_stb && !clr_stb && !ld_stb && !spi_miso && !spi_miso_oe,
            "R12 reset outputs", {rd_stb, wr_stb, clr_stb, ld_stb, spi_miso, spi_miso_oe}, 64'h0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         logic [1:0]  cw;
         logic [7:0]  ins;
         int          ns, rb;
         logic [39:0] txd;
         logic [2:0]  kind;
         logic [31:0] wexp;
         int b_rd, b_wr, b_clr, b_ld;
         cw   = VEC[v][90:89];
         ins  = VEC[v][88:81];
         ns   = int'(VEC[v][80:78]);
         txd  = VEC[v][77:38];
         kind = VEC[v][37:35];
         wexp = VEC[v][34:3];
         rb   = int'(VEC[v][2:0]);
         cfg_width = cw;
         repeat (2) @(negedge clk);
         b_rd = n_rd; b_wr = n_wr; b_clr = n_clr; b_ld = n_ld;
         tx48 = {ins, 40'h0} | ({8'h0, txd} << (8 * (5 - ns)));
         xfer(8 + 8 * ns, tx48, rx48);
         check((n_rd - b_rd == int'(kind == K_RD)) && (n_wr - b_wr == int'(kind == K_WR)) &&
               (n_clr - b_clr == int'(kind == K_CLR)) && (n_ld - b_ld == int'(kind == K_LD)),
               $sformatf("R1/R8/R9/R11 strobe count vector %0d", v),
               {32'(n_rd - b_rd), 8'(n_wr - b_wr), 8'(n_clr - b_clr), 8'(n_ld - b_ld), 8'(kind)},
               {56'h0, 5'h0, kind});
         if (kind != K_NONE)
            check(last_sel == ins[5:3], $sformatf("R1 reg_sel vector %0d", v), 64'(last_sel), 64'(ins[5:3]));
         if (kind == K_WR)
            check(last_wdata == wexp, $sformatf("R2/R4/R5/R6 wdata vector %0d", v), 64'(last_wdata), 64'(wexp));
         if (kind == K_RD) begin
            mval  = 64'(rd_model(ins[5:3])) & ((64'd1 << (8 * rb)) - 64'd1);
            exp48 = (48'(mval) << (8 * (ns - rb))) << (8 * (5 - ns));
         end else begin
            exp48 = '0;
         end
         check(rx48 == exp48, $sformatf("R3/R6/R7 miso stream vector %0d", v), 64'(rx48), 64'(exp48));
      end

      // R10: idle line quiet
      check(!spi_miso && !spi_miso_oe, "R10 idle miso", {spi_miso, spi_miso_oe}, 64'h0);
      @(negedge clk);
      spi_cs_n = 1'b0;
      repeat (8) @(negedge clk);
      check(spi_miso_oe == 1'b1, "R10 selected drive enable", 64'(spi_miso_oe), 64'h1);
      spi_cs_n = 1'b1;
      repeat (16) @(negedge clk);

      // R9: frame dropped mid-instruction, then a fresh frame
      begin
         int b_clr;
         b_clr = n_clr;
         xfer(4, {8'h20, 40'h0}, rx48);
         check(n_clr == b_clr && n_rd + n_wr + n_ld > 0, "R9 aborted instruction", 64'(n_clr - b_clr), 64'h0);
         xfer(8, {8'h20, 40'h0}, rx48);
         check(n_clr - b_clr == 1, "R9 new frame accepted", 64'(n_clr - b_clr), 64'h1);
      end

      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end

endmodule